// File: doc/BRIEF.md
# Size-Classed Receive Ring Selector

This block sits between a receive store-and-forward buffer and the descriptor write-back path of a network receive engine. The buffer reports each finished frame together with its full byte count, so the length is known before any buffer is claimed. The block steers that frame into one of four descriptor rings. Each ring carries buffers of a different fixed capacity, and the chosen ring is always the smallest one whose buffer can hold the frame.

For every ring the block keeps a head index that wraps at a programmable descriptor count. It looks up the head descriptor through a simple combinational request: a ring and an index go out, and a hardware-ownership flag comes back. When the flag is set, it issues a write-back carrying the ring, the index, the length and the status, held under a valid/ready handshake. Acceptance of the write-back marks the frame as fully stored and sets that ring's completion bit. Drops are recorded in sticky status bits: one overflow bit per ring for a missing descriptor, and one bit for frames too long for any ring. Every status bit has its own enable into a single interrupt line.

Top module: `rx_ring_sel`

## Requirements
- R1: A frame of length L is steered to the ring with the smallest capacity that is at least L. With the default capacities, ring 0 holds 64, ring 1 holds 128, ring 2 holds 256 and ring 3 holds 2048 bytes. The choice appears on `desc_ring_o`, and `desc_req_o` is high during the cycle in which the frame is offered.
- R2: A frame longer than the largest capacity raises no descriptor request and no write-back, and moves no head index. It sets status bit 8 (oversize).
- R3: Each ring's head index starts at 0, advances by one for every frame stored in that ring, and returns to 0 after entry `desc_cnt_i[r]-1`. The head of the chosen ring is shown on `desc_idx_o`. Each count must be at least 1.
- R4: If `desc_hw_own_i` is low while a descriptor is requested, the frame is dropped and status bit 4+r (overflow of ring r) is set. The head does not move, no write-back occurs, and no larger ring is tried.
- R5: On the clock edge after a stored frame is accepted, `wb_valid_o` rises. At the same time the write-back fields take their values: ring, index and length, with status bit 0 = 1 for a stored frame and status bit 1 = 1 when the length equals the ring capacity. These outputs hold until `wb_ready_i` is sampled high. While they wait, `pkt_ready_o` stays low.
- R6: On the edge where `wb_valid_o` and `wb_ready_i` are both high, status bit r (completion of ring r) is set for the written ring.
- R7: Status bits are sticky and are cleared by writing one on `irq_clr_i`. A set and a clear of the same bit in the same cycle leave the bit set.
- R8: `irq_o` is high exactly when some status bit and its matching bit of `irq_en_i` are both high, so each source can be disabled on its own.
- R9: After reset all heads are 0, the status is 0, `wb_valid_o` is low and `pkt_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Completed frame offered |
| pkt_len_i | input | LEN_W | Frame length in bytes |
| pkt_ready_o | output | 1 | Frame can be taken |
| desc_cnt_i | input | 4*IDX_W | Descriptor count per ring |
| desc_req_o | output | 1 | Descriptor lookup active |
| desc_ring_o | output | 2 | Ring of the lookup |
| desc_idx_o | output | IDX_W | Head index of the lookup |
| desc_hw_own_i | input | 1 | Looked-up descriptor owned by hardware |
| wb_valid_o | output | 1 | Write-back pending |
| wb_ready_i | input | 1 | Write-back accepted |
| wb_ring_o | output | 2 | Write-back ring |
| wb_idx_o | output | IDX_W | Write-back descriptor index |
| wb_len_o | output | LEN_W | Write-back frame length |
| wb_status_o | output | 2 | Write-back status |
| irq_en_i | input | 9 | Per-source interrupt enables |
| irq_clr_i | input | 9 | Write-one-to-clear strobes |
| irq_stat_o | output | 9 | Sticky status: [3:0] done, [7:4] overflow, [8] oversize |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the wrap of a ring head that has been interleaved with drops. A drop leaves the head in place, so the wrap point moves by one for every refused descriptor. To reach it, the bench programs small counts per ring and sends a long random mix of lengths across every size class. It withholds ownership on a fraction of the frames and tracks each head in its own model. The bench also clears a completion bit in the same cycle its write-back is accepted, which exercises the set-over-clear priority directly.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int NRING  = 4;
  localparam int RW     = 2;
  localparam int STAT_W = 2 * NRING + 1;
  localparam int OVS_B  = 2 * NRING;
  typedef logic [RW-1:0] ring_t;
endpackage

// File: rtl/rx_ring_class.sv
module rx_ring_class
  import rx_ring_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter logic [NRING-1:0][LEN_W-1:0] CAPS = '0
) (
  input  logic [LEN_W-1:0] len_i,
  output ring_t            ring_o,
  output logic             oversize_o,
  output logic             exact_o
);
  logic [NRING-1:0] fit;

  for (genvar g = 0; g < NRING; g++) begin : g_fit
    assign fit[g] = (len_i <= CAPS[g]);
  end

  always_comb begin
    ring_o = ring_t'(NRING - 1);
    for (int i = NRING - 1; i >= 0; i--) begin
      if (fit[i]) ring_o = ring_t'(i);
    end
  end

  assign oversize_o = ~fit[NRING-1];
  assign exact_o    = (len_i == CAPS[ring_o]);
endmodule

// File: rtl/rx_ring_head.sv
module rx_ring_head #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] cnt_i,
  output logic [IDX_W-1:0] head_o
);
  logic [IDX_W-1:0] last;
  assign last = cnt_i - IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) head_o <= '0;
    else if (adv_i) head_o <= (head_o >= last) ? '0 : head_o + IDX_W'(1);
  end
endmodule

// File: rtl/rx_ring_irq.sv
module rx_ring_irq #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else stat_o <= (stat_o & ~clr_i) | set_i;
  end

  assign irq_o = |(stat_o & en_i);
endmodule

// File: rtl/rx_ring_sel.sv
module rx_ring_sel
  import rx_ring_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int IDX_W = 6,
  parameter int CAP0  = 64,
  parameter int CAP1  = 128,
  parameter int CAP2  = 256,
  parameter int CAP3  = 2048
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        pkt_valid_i,
  input  logic [LEN_W-1:0]            pkt_len_i,
  output logic                        pkt_ready_o,
  input  logic [NRING-1:0][IDX_W-1:0] desc_cnt_i,
  output logic                        desc_req_o,
  output logic [RW-1:0]               desc_ring_o,
  output logic [IDX_W-1:0]            desc_idx_o,
  input  logic                        desc_hw_own_i,
  output logic                        wb_valid_o,
  input  logic                        wb_ready_i,
  output logic [RW-1:0]               wb_ring_o,
  output logic [IDX_W-1:0]            wb_idx_o,
  output logic [LEN_W-1:0]            wb_len_o,
  output logic [1:0]                  wb_status_o,
  input  logic [STAT_W-1:0]           irq_en_i,
  input  logic [STAT_W-1:0]           irq_clr_i,
  output logic [STAT_W-1:0]           irq_stat_o,
  output logic                        irq_o
);
  localparam logic [NRING-1:0][LEN_W-1:0] CAPS =
    {LEN_W'(CAP3), LEN_W'(CAP2), LEN_W'(CAP1), LEN_W'(CAP0)};

  ring_t                       cls_ring;
  logic                        cls_ovs, cls_exact;
  logic                        fire, take, miss, wb_done;
  logic [NRING-1:0]            adv;
  logic [NRING-1:0][IDX_W-1:0] head;
  logic [STAT_W-1:0]           set_v;

  rx_ring_class #(.LEN_W(LEN_W), .CAPS(CAPS)) class_i (
    .len_i      (pkt_len_i),
    .ring_o     (cls_ring),
    .oversize_o (cls_ovs),
    .exact_o    (cls_exact)
  );

  assign pkt_ready_o = ~wb_valid_o;
  assign fire        = pkt_valid_i & pkt_ready_o;
  assign desc_req_o  = fire & ~cls_ovs;
  assign desc_ring_o = cls_ring;
  assign desc_idx_o  = head[cls_ring];
  assign take        = desc_req_o & desc_hw_own_i;
  assign miss        = desc_req_o & ~desc_hw_own_i;
  assign wb_done     = wb_valid_o & wb_ready_i;

  for (genvar r = 0; r < NRING; r++) begin : g_ring
    assign adv[r] = take & (cls_ring == ring_t'(r));
    rx_ring_head #(.IDX_W(IDX_W)) head_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (adv[r]),
      .cnt_i  (desc_cnt_i[r]),
      .head_o (head[r])
    );
    assign set_v[r]         = wb_done & (wb_ring_o == ring_t'(r));
    assign set_v[NRING + r] = miss & (cls_ring == ring_t'(r));
  end
  assign set_v[OVS_B] = fire & cls_ovs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o  <= 1'b0;
      wb_ring_o   <= '0;
      wb_idx_o    <= '0;
      wb_len_o    <= '0;
      wb_status_o <= '0;
    end else if (take) begin
      wb_valid_o  <= 1'b1;
      wb_ring_o   <= cls_ring;
      wb_idx_o    <= head[cls_ring];
      wb_len_o    <= pkt_len_i;
      wb_status_o <= {cls_exact, 1'b1};
    end else if (wb_done) begin
      wb_valid_o  <= 1'b0;
    end
  end

  rx_ring_irq #(.W(STAT_W)) irq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (irq_clr_i),
    .en_i   (irq_en_i),
    .stat_o (irq_stat_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/rx_ring_sel_chk.sv
module rx_ring_sel_chk
  import rx_ring_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int IDX_W = 6,
  parameter int CAP0  = 64,
  parameter int CAP1  = 128,
  parameter int CAP2  = 256,
  parameter int CAP3  = 2048
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        pkt_valid_i,
  input logic [LEN_W-1:0]            pkt_len_i,
  input logic                        pkt_ready_o,
  input logic [NRING-1:0][IDX_W-1:0] desc_cnt_i,
  input logic                        desc_req_o,
  input logic [RW-1:0]               desc_ring_o,
  input logic [IDX_W-1:0]            desc_idx_o,
  input logic                        desc_hw_own_i,
  input logic                        wb_valid_o,
  input logic                        wb_ready_i,
  input logic [RW-1:0]               wb_ring_o,
  input logic [IDX_W-1:0]            wb_idx_o,
  input logic [LEN_W-1:0]            wb_len_o,
  input logic [1:0]                  wb_status_o,
  input logic [STAT_W-1:0]           irq_en_i,
  input logic [STAT_W-1:0]           irq_clr_i,
  input logic [STAT_W-1:0]           irq_stat_o,
  input logic                        irq_o
);
  function automatic int cap_of(input int r);
    case (r)
      0: cap_of = CAP0;
      1: cap_of = CAP1;
      2: cap_of = CAP2;
      default: cap_of = CAP3;
    endcase
  endfunction

  function automatic int floor_of(input int r);
    floor_of = (r == 0) ? -1 : cap_of(r - 1);
  endfunction

  p_fit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (int'(wb_len_o) <= cap_of(int'(wb_ring_o))) &&
                   (int'(wb_len_o) > floor_of(int'(wb_ring_o))));

  p_ovs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_ready_o && int'(pkt_len_i) > CAP3) |-> !desc_req_o);

  p_idx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_idx_o < desc_cnt_i[wb_ring_o]));

  p_miss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_req_o && !desc_hw_own_i) |=> !wb_valid_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> wb_valid_o && $stable(wb_len_o) &&
      $stable(wb_idx_o) && $stable(wb_ring_o) && $stable(wb_status_o));

  p_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> !pkt_ready_o);

  p_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_ready_i) |=> irq_stat_o[$past(wb_ring_o)]);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_stat_o & $past(irq_stat_o & ~irq_clr_i)) ==
              $past(irq_stat_o & ~irq_clr_i)));

  p_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o);
endmodule

bind rx_ring_sel rx_ring_sel_chk #(
  .LEN_W(LEN_W), .IDX_W(IDX_W),
  .CAP0(CAP0), .CAP1(CAP1), .CAP2(CAP2), .CAP3(CAP3)
) chk_i (.*);

// File: tb/rx_ring_sel_tb.sv
module rx_ring_sel_tb_top;
  localparam int CLK_P = 10;
  localparam int LEN_W = 12;
  localparam int IDX_W = 6;
  localparam int SW    = 9;

  logic clk = 0, rst_n = 0;
  logic pkt_valid = 0, pkt_ready;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [3:0][IDX_W-1:0] desc_cnt;
  logic desc_req, desc_own = 0;
  logic [1:0] desc_ring;
  logic [IDX_W-1:0] desc_idx;
  logic wb_valid, wb_ready = 0;
  logic [1:0] wb_ring, wb_status;
  logic [IDX_W-1:0] wb_idx;
  logic [LEN_W-1:0] wb_len;
  logic [SW-1:0] irq_en = '0, irq_clr = '0, irq_stat;
  logic irq;

  int checks = 0, errors = 0;
  int head_m[4];
  int cnt_m[4] = '{3, 2, 4, 1};
  logic [SW-1:0] stat_m = '0;
  bit fin = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_ring_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .pkt_valid_i(pkt_valid), .pkt_len_i(pkt_len), .pkt_ready_o(pkt_ready),
    .desc_cnt_i(desc_cnt), .desc_req_o(desc_req), .desc_ring_o(desc_ring),
    .desc_idx_o(desc_idx), .desc_hw_own_i(desc_own),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_ring_o(wb_ring),
    .wb_idx_o(wb_idx), .wb_len_o(wb_len), .wb_status_o(wb_status),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .irq_stat_o(irq_stat), .irq_o(irq)
  );

  function automatic int cap_f(input int r);
    case (r) 0: return 64; 1: return 128; 2: return 256; default: return 2048; endcase
  endfunction

  function automatic int ring_f(input int len);
    for (int r = 0; r < 4; r++) if (len <= cap_f(r)) return r;
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_stat();
    chk("R7 status", int'(irq_stat), int'(stat_m));
    chk("R8 irq", int'(irq), int'(|(stat_m & irq_en)));
  endtask

  task automatic send(input int len, input bit own, input logic [SW-1:0] hs_clr);
    int er = ring_f(len);
    @(negedge clk);
    pkt_valid = 1; pkt_len = LEN_W'(len); desc_own = own;
    #1;
    chk("R5 ready", int'(pkt_ready), 1);
    if (er < 0) chk("R2 no req", int'(desc_req), 0);
    else begin
      chk("R1 req", int'(desc_req), 1);
      chk("R1 ring", int'(desc_ring), er);
      chk("R3 idx", int'(desc_idx), head_m[er]);
    end
    @(posedge clk); #1;
    pkt_valid = 0;
    if (er < 0) begin
      stat_m[8] = 1'b1;
      chk("R2 no wb", int'(wb_valid), 0);
    end else if (!own) begin
      stat_m[4+er] = 1'b1;
      chk("R4 no wb", int'(wb_valid), 0);
    end else begin
      chk("R5 wb valid", int'(wb_valid), 1);
      chk("R5 wb ring", int'(wb_ring), er);
      chk("R5 wb idx", int'(wb_idx), head_m[er]);
      chk("R5 wb len", int'(wb_len), len);
      chk("R5 wb status", int'(wb_status), (len == cap_f(er)) ? 3 : 1);
      head_m[er] = (head_m[er] + 1 >= cnt_m[er]) ? 0 : head_m[er] + 1;
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        @(posedge clk); #1;
        chk("R5 hold", int'(wb_valid && wb_len == LEN_W'(len) && !pkt_ready), 1);
      end
      wb_ready = 1; irq_clr = hs_clr;
      @(posedge clk); #1;
      wb_ready = 0; irq_clr = '0;
      stat_m = (stat_m & ~hs_clr);
      stat_m[er] = 1'b1;
      chk("R6 wb done", int'(wb_valid), 0);
      chk("R6 done bit", int'(irq_stat[er]), 1);
    end
    chk_stat();
  endtask

  task automatic clear(input logic [SW-1:0] m);
    @(negedge clk);
    irq_clr = m;
    @(posedge clk); #1;
    irq_clr = '0;
    stat_m = stat_m & ~m;
    chk_stat();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sel, len;
    void'($urandom(32'h5eed));
    for (int r = 0; r < 4; r++) begin
      desc_cnt[r] = IDX_W'(cnt_m[r]);
      head_m[r] = 0;
    end
    #(CLK_P * 2 + 1);
    chk("R9 wb valid", int'(wb_valid), 0);
    chk("R9 ready", int'(pkt_ready), 1);
    chk("R9 status", int'(irq_stat), 0);
    @(negedge clk); rst_n = 1;
    irq_en = '1;
    // boundaries of every size class
    send(64, 1, '0);   send(65, 1, '0);   send(128, 1, '0);
    send(129, 1, '0);  send(256, 1, '0);  send(257, 1, '0);
    send(2048, 1, '0); send(0, 1, '0);
    send(2049, 1, '0); send(4095, 1, '0);
    // drop on ring 1 keeps head in place, no fallback ring
    send(100, 0, '0);  send(100, 1, '0);  send(100, 1, '0);
    clear(9'h1ff);
    // set beats clear in the same cycle
    send(10, 1, 9'h001);
    chk("R7 set wins", int'(irq_stat[0]), 1);
    clear(9'h001);
    // per-source enable masking
    send(3000, 1, '0);
    irq_en = 9'h0ff; #1; chk_stat();
    irq_en = 9'h100; #1; chk_stat();
    for (int n = 0; n < 400; n++) begin
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: len = $urandom_range(0, 64);
        2, 3: len = $urandom_range(65, 128);
        4, 5: len = $urandom_range(129, 256);
        6, 7: len = $urandom_range(257, 2048);
        default: len = $urandom_range(2049, 4095);
      endcase
      send(len, ($urandom_range(0, 4) != 0), '0);
      if ($urandom_range(0, 5) == 0) clear(SW'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        irq_en = SW'($urandom); #1; chk_stat();
      end
    end
    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule